// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a single-port synchronous SRAM with a 32-bit data path split into four byte lanes. Its depth is set by a parameter. All commands are captured on the rising clock edge. These are the address, the two address strobes, the advance input, three chip enables and the write controls. An access is started from either a processor-side strobe or a controller-side strobe. After that, a small burst counter generates the following addresses. The counter steps in linear or interleaved order, picked by a static input. It advances only while the advance input is low. A write stores the data present on the data input in the same cycle as the command.

A static mode input selects the read latency. In flow-through mode the data comes straight from the array behind the registered read address. In pipelined mode it passes through an extra output register. Deselect commands and writes travel down the same read pipeline as reads. The bus therefore turns off after the same number of edges that a read takes to turn it on. The output enable and the sleep input act without a clock. While sleep is high, every command is ignored and the stored data is kept.

The data bus is presented as a separate input, an output, and a drive-enable that an I/O cell would use to control the shared pins.

Top module: `burst_sram`

## Requirements
- R1: When allWrN is low during a write command, all four lanes are written, whatever byteWrN and laneSelN hold.
- R2: With allWrN high and byteWrN low, lane i (dqIn bits 8i+7..8i) is written exactly when laneSelN[i] is low, in any combination. Other lanes keep their contents. If every laneSelN bit is high, the command is a read.
- R3: With pipeMode low, a read command taken at edge k drives dqOe high with the addressed word on dqOut during the cycle after edge k.
- R4: With pipeMode high, a read command taken at edge k leaves dqOe low after edge k, unless an earlier read is still in flight. It drives the word after edge k+1.
- R5: A burst's low two address bits step as base+n (mod 4) when linearOrder is high and as base XOR n when it is low. The step count n rises by one on each edge with advanceN low, holds while advanceN is high, and wraps to the base after the fourth beat.
- R6: A deselect command (a strobe with the chip not selected) ends the burst. It turns dqOe off after one edge in flow-through mode and after two edges in pipelined mode. In pipelined mode, the previous read stays on the bus during the cycle in between.
- R7: The processor-side strobe is ignored while enPrimN is high, and the burst continues. A processor-side start checks only enPrimN and enHi, and it is always a read. A controller-side start also requires enCtrlN low, and it honours the write controls.
- R8: oeN high forces dqOe low at once, without a clock edge, and leaves the burst and the read pipeline unchanged.
- R9: sleep high forces dqOe low at once. Commands taken while it is high are ignored, the memory contents are kept, and a command on the first edge after release is accepted.
- R10: During and right after reset, dqOe is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| pipeMode | input | 1 | Static: 1 adds the output register, 0 is flow-through |
| linearOrder | input | 1 | Static: 1 linear burst order, 0 interleaved |
| sleep | input | 1 | Asynchronous low-power request, active high |
| oeN | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| enPrimN | input | 1 | Primary chip enable, active low |
| enHi | input | 1 | Chip enable, active high |
| enCtrlN | input | 1 | Chip enable sampled only with the controller-side strobe, active low |
| allWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Lane-write enable, active low |
| laneSelN | input | 4 | Per-lane write selects, active low |
| dqIn | input | 32 | Write data |
| dqOut | output | 32 | Read data |
| dqOe | output | 1 | Bus drive enable |

## Verification
Writes take effect at the command's own edge. A flow-through read is due one edge after its command and a pipelined read two edges after. A deselect removes the drive with that same spacing, and oeN and sleep act at once, with no edge. The bench drives inputs 1 ns after a rising edge. A reference model then takes each command at the next edge and shifts it through a one- or two-stage expected pipeline, picked by the mode, and compares dqOe and dqOut 1 ns after every edge. The asynchronous cases are sampled 1 ns after the input changes, between edges. Directed sequences check the exact beat on which each burst address, deselect and wake-up shows, and constrained random traffic covers the mix of these.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // strobes handed from the control to the array datapath
  typedef struct packed {
    logic             rdIssue;
    logic             wrEn;
    logic [LANES-1:0] laneWr;
  } memStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              linearOrder,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              enPrimN,
  input  logic              enHi,
  input  logic              enCtrlN,
  input  logic              allWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneSelN,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] accAddr,
  output logic              driveEn
);
  logic               active;
  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt, nextCnt, seqLow;
  logic               rdStage1, rdStage2;
  logic [LANES-1:0]   laneReq;
  logic               procStart, ctrlStart;
  logic               loadAddr, advance, accEn, wrReq, deselCmd;

  // lane selection: the global write overrides the per-lane selects
  always_comb begin
    if (!allWrN)       laneReq = '1;
    else if (!byteWrN) laneReq = ~laneSelN;
    else               laneReq = '0;
  end

  // the processor strobe counts only while the primary enable is low
  assign procStart = !procStrobeN && !enPrimN;
  assign ctrlStart = !procStart && !ctrlStrobeN;

  always_comb begin
    loadAddr = 1'b0;
    advance  = 1'b0;
    accEn    = 1'b0;
    wrReq    = 1'b0;
    deselCmd = 1'b0;
    nextCnt  = beatCnt;
    if (!sleep) begin
      if (procStart) begin
        if (enHi) begin
          loadAddr = 1'b1;
          accEn    = 1'b1;
        end else begin
          deselCmd = 1'b1;
        end
      end else if (ctrlStart) begin
        if (!enPrimN && enHi && !enCtrlN) begin
          loadAddr = 1'b1;
          accEn    = 1'b1;
          wrReq    = |laneReq;
        end else begin
          deselCmd = 1'b1;
        end
      end else if (active) begin
        accEn = 1'b1;
        wrReq = |laneReq;
        if (!advanceN) begin
          advance = 1'b1;
          nextCnt = beatCnt + BURST_W'(1);
        end
      end
    end
  end

  assign seqLow  = linearOrder ? (baseAddr[BURST_W-1:0] + nextCnt)
                               : (baseAddr[BURST_W-1:0] ^ nextCnt);
  assign accAddr = loadAddr ? addr : {baseAddr[ADDR_W-1:BURST_W], seqLow};

  assign strobe.rdIssue = accEn && !wrReq;
  assign strobe.wrEn    = accEn && wrReq;
  assign strobe.laneWr  = laneReq & {LANES{accEn && wrReq}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (sleep || deselCmd) begin
      active   <= 1'b0;
    end else if (loadAddr) begin
      active   <= 1'b1;
      baseAddr <= addr;
      beatCnt  <= '0;
    end else if (advance) begin
      beatCnt  <= nextCnt;
    end
  end

  // read/deselect pipeline: a deselect or write enters as an empty slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage1 <= 1'b0;
      rdStage2 <= 1'b0;
    end else begin
      rdStage1 <= accEn && !wrReq;
      rdStage2 <= sleep ? 1'b0 : rdStage1;
    end
  end

  assign driveEn = pipeMode ? rdStage2 : rdStage1;

  assert_all_lanes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !allWrN) |-> (strobe.laneWr == '1));

  assert_ft_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && strobe.rdIssue) |=> driveEn);

  assert_pipe_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(strobe.rdIssue && rstN) && !sleep) |=> driveEn);

  assert_burst_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && beatCnt == '1) |=> (beatCnt == '0));

  assert_desel_ft_R6: assert property (@(posedge clk) disable iff (!rstN)
    (deselCmd && !pipeMode) |=> !driveEn);

  assert_desel_pipe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(deselCmd && rstN)) |=> !driveEn);

  assert_proc_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && enPrimN && ctrlStrobeN && !active) |-> !(strobe.rdIssue || strobe.wrEn));

  assert_sleep_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !active);
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] flowData, pipeReg;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.laneWr[l])
          mem[accAddr][l*LANE_W +: LANE_W] <= dataIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdAddr <= '0;
    else if (strobe.rdIssue) rdAddr <= accAddr;
  end

  assign flowData = mem[rdAddr];

  always_ff @(posedge clk) pipeReg <= flowData;

  assign dataOut = pipeMode ? pipeReg : flowData;

  assert_lane_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (|strobe.laneWr && !strobe.rdIssue));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              linearOrder,
  input  logic              sleep,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              enPrimN,
  input  logic              enHi,
  input  logic              enCtrlN,
  input  logic              allWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] accAddr;
  logic              driveEn;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linearOrder(linearOrder),
    .sleep(sleep), .addr(addr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .enPrimN(enPrimN),
    .enHi(enHi), .enCtrlN(enCtrlN), .allWrN(allWrN), .byteWrN(byteWrN),
    .laneSelN(laneSelN), .strobe(strobe), .accAddr(accAddr), .driveEn(driveEn)
  );

  burst_sram_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .strobe(strobe),
    .accAddr(accAddr), .dataIn(dqIn), .dataOut(dqOut)
  );

  // output enable and sleep gate the drive without waiting for a clock
  assign dqOe = driveEn && !oeN && !sleep;

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe);

  assert_sleep_float_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dqOe);
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN, pipeMode, linearOrder, sleep, oeN;
  logic [AW-1:0] addr;
  logic          procStrobeN, ctrlStrobeN, advanceN, enPrimN, enHi, enCtrlN;
  logic          allWrN, byteWrN;
  logic [3:0]    laneSelN;
  logic [31:0]   dqIn, dqOut;
  logic          dqOe;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linearOrder(linearOrder),
    .sleep(sleep), .oeN(oeN), .addr(addr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .enPrimN(enPrimN),
    .enHi(enHi), .enCtrlN(enCtrlN), .allWrN(allWrN), .byteWrN(byteWrN),
    .laneSelN(laneSelN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int    checks = 0, errors = 0;
  string curReq = "R10";
  bit    done = 0;

  // reference model state
  logic [31:0]   mMem [DEPTH];
  bit            mActive, v1, v2;
  logic [AW-1:0] mBase;
  logic [1:0]    mCnt;
  logic [31:0]   d1, d2;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] beatLow(input logic [1:0] base, input logic [1:0] n, input bit lin);
    return lin ? base + n : base ^ n;
  endfunction

  task automatic idleIn();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    enPrimN = 0; enHi = 1; enCtrlN = 0;
    allWrN = 1; byteWrN = 1; laneSelN = 4'hF;
  endtask

  // one clock: model the command, take the edge, compare 1 ns later
  task automatic step();
    bit ld = 0, acc = 0, wr = 0, des = 0, expOe;
    logic [3:0] lanes;
    logic [1:0] nc = mCnt;
    logic [AW-1:0] ea;
    lanes = !allWrN ? 4'hF : (!byteWrN ? ~laneSelN : 4'h0);
    if (!sleep) begin
      if (!procStrobeN && !enPrimN) begin
        if (enHi) begin ld = 1; acc = 1; end else des = 1;
      end else if (!ctrlStrobeN) begin
        if (!enPrimN && enHi && !enCtrlN) begin ld = 1; acc = 1; wr = |lanes; end
        else des = 1;
      end else if (mActive) begin
        acc = 1; wr = |lanes;
        if (!advanceN) nc = mCnt + 2'd1;
      end
    end
    ea = ld ? addr : {mBase[AW-1:2], beatLow(mBase[1:0], nc, linearOrder)};
    @(posedge clk);
    if (wr)
      for (int l = 0; l < 4; l++)
        if (lanes[l]) mMem[ea][l*8 +: 8] = dqIn[l*8 +: 8];
    v2 = sleep ? 1'b0 : v1;
    d2 = d1;
    v1 = acc && !wr;
    d1 = mMem[ea];
    if (sleep || des) mActive = 0;
    else if (ld) begin mActive = 1; mBase = addr; mCnt = 0; end
    else if (acc) mCnt = nc;
    #1;
    expOe = (pipeMode ? v2 : v1) && !oeN && !sleep;
    check({curReq, " drive"}, {31'd0, dqOe}, {31'd0, expOe});
    if (expOe) check({curReq, " data"}, dqOut, pipeMode ? d2 : d1);
  endtask

  task automatic ctrlCmd(input logic [AW-1:0] a, input bit gw, input bit bw,
                         input logic [3:0] sel, input logic [31:0] d);
    idleIn();
    ctrlStrobeN = 0; addr = a; allWrN = gw; byteWrN = bw; laneSelN = sel; dqIn = d;
    step();
    idleIn();
  endtask

  task automatic setMode(input bit pm, input bit lin);
    idleIn();
    ctrlStrobeN = 0; enHi = 0;
    step();
    idleIn();
    step(); step();
    pipeMode = pm; linearOrder = lin;
  endtask

  initial begin
    logic [31:0] old;
    logic [AW-1:0] seqA [5];
    void'($urandom(32'd2718));
    rstN = 0; pipeMode = 1; linearOrder = 1; sleep = 0; oeN = 0;
    addr = '0; dqIn = '0;
    idleIn();
    mActive = 0; v1 = 0; v2 = 0; mBase = '0; mCnt = 0; d1 = '0; d2 = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset drive", {31'd0, dqOe}, 32'd0);
    rstN = 1;
    curReq = "R10";
    step();
    check("R10 idle after reset", {31'd0, dqOe}, 32'd0);

    // R1: global write overrides any lane controls while filling memory
    curReq = "R1";
    for (int a = 0; a < DEPTH; a++)
      ctrlCmd(AW'(a), 1'b0, 1'($urandom), 4'($urandom), $urandom);
    ctrlCmd(8'h07, 1'b1, 1'b1, 4'hF, 32'h0);
    step();
    check("R1 full word", dqOut, mMem[7]);

    // R2: partial lane write, lanes 0 and 2 selected
    curReq = "R2";
    old = mMem[5];
    ctrlCmd(8'h05, 1'b1, 1'b0, 4'b1010, 32'hAABBCCDD);
    ctrlCmd(8'h05, 1'b1, 1'b1, 4'hF, 32'h0);
    step();
    check("R2 lane merge", dqOut, {old[31:24], 8'hBB, old[15:8], 8'hDD});
    ctrlCmd(8'h06, 1'b1, 1'b0, 4'hF, 32'h12345678);
    step();
    check("R2 no lane is read drive", {31'd0, dqOe}, 32'd1);
    check("R2 no lane is read data", dqOut, mMem[6]);

    // R3: flow-through latency
    curReq = "R3";
    setMode(1'b0, 1'b1);
    ctrlCmd(8'h09, 1'b1, 1'b1, 4'hF, 32'h0);
    check("R3 one edge", {31'd0, dqOe}, 32'd1);
    check("R3 data", dqOut, mMem[9]);

    // R4: pipelined latency
    curReq = "R4";
    setMode(1'b1, 1'b1);
    ctrlCmd(8'h09, 1'b1, 1'b1, 4'hF, 32'h0);
    check("R4 not yet", {31'd0, dqOe}, 32'd0);
    step();
    check("R4 two edges", {31'd0, dqOe}, 32'd1);
    check("R4 data", dqOut, mMem[9]);

    // R5: burst orders, wrap and hold (flow-through, one beat per edge)
    curReq = "R5";
    for (int lin = 0; lin < 2; lin++) begin
      setMode(1'b0, 1'(lin));
      for (int n = 0; n < 5; n++)
        seqA[n] = {6'h10, beatLow(2'd1, 2'(n), 1'(lin))};
      ctrlCmd(8'h41, 1'b1, 1'b1, 4'hF, 32'h0);
      check("R5 beat0", dqOut, mMem[seqA[0]]);
      for (int n = 1; n < 5; n++) begin
        advanceN = 0;
        step();
        check("R5 beat", dqOut, mMem[seqA[n]]);
      end
      advanceN = 1;
      step();
      check("R5 hold", dqOut, mMem[seqA[4]]);
    end

    // R6: deselect timing in both modes
    curReq = "R6";
    setMode(1'b1, 1'b1);
    ctrlCmd(8'h10, 1'b1, 1'b1, 4'hF, 32'h0);
    ctrlStrobeN = 0; enHi = 0;
    step();
    idleIn();
    check("R6 pipe read still on", dqOut, mMem[8'h10]);
    step();
    check("R6 pipe off after two edges", {31'd0, dqOe}, 32'd0);
    setMode(1'b0, 1'b1);
    ctrlCmd(8'h11, 1'b1, 1'b1, 4'hF, 32'h0);
    ctrlStrobeN = 0; enHi = 0;
    step();
    idleIn();
    check("R6 ft off after one edge", {31'd0, dqOe}, 32'd0);

    // R7: masked processor strobe, enable sampling per strobe
    curReq = "R7";
    ctrlCmd(8'h20, 1'b1, 1'b1, 4'hF, 32'h0);
    procStrobeN = 0; enPrimN = 1; addr = 8'h99; advanceN = 0;
    step();
    idleIn();
    check("R7 masked strobe continues", dqOut, mMem[8'h21]);
    old = mMem[8'h30];
    procStrobeN = 0; enCtrlN = 1; allWrN = 0; addr = 8'h30; dqIn = ~old;
    step();
    idleIn();
    check("R7 proc start reads", {31'd0, dqOe}, 32'd1);
    check("R7 proc start no write", dqOut, old);
    ctrlStrobeN = 0; enCtrlN = 1; addr = 8'h31;
    step();
    idleIn();
    check("R7 ctrl start needs enCtrlN", {31'd0, dqOe}, 32'd0);

    // R8: asynchronous output enable
    curReq = "R8";
    ctrlCmd(8'h44, 1'b1, 1'b1, 4'hF, 32'h0);
    oeN = 1;
    #1;
    check("R8 async off", {31'd0, dqOe}, 32'd0);
    advanceN = 0;
    step();
    advanceN = 1;
    oeN = 0;
    #1;
    check("R8 async on", {31'd0, dqOe}, 32'd1);
    check("R8 burst kept", dqOut, mMem[8'h45]);

    // R9: sleep
    curReq = "R9";
    setMode(1'b1, 1'b1);
    old = mMem[8'h50];
    ctrlCmd(8'h50, 1'b1, 1'b1, 4'hF, 32'h0);
    step();
    sleep = 1;
    #1;
    check("R9 async off", {31'd0, dqOe}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      ctrlStrobeN = 0; addr = 8'h50; allWrN = 0; dqIn = ~old;
      step();
    end
    idleIn();
    sleep = 0;
    ctrlCmd(8'h50, 1'b1, 1'b1, 4'hF, 32'h0);
    step();
    check("R9 retained and resumed", dqOut, old);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      if (i % 250 == 249) setMode(1'($urandom), 1'($urandom));
      curReq = pipeMode ? "R4" : "R3";
      idleIn();
      r = $urandom % 16;
      addr = AW'($urandom); dqIn = $urandom;
      enPrimN  = ($urandom % 8) == 0;
      enHi     = ($urandom % 8) != 0;
      enCtrlN  = ($urandom % 8) == 0;
      allWrN   = ($urandom % 6) != 0;
      byteWrN  = 1'($urandom);
      laneSelN = 4'($urandom);
      advanceN = 1'($urandom);
      oeN      = ($urandom % 10) == 0;
      sleep    = ($urandom % 40) == 0;
      if (r < 3) ctrlStrobeN = 0;
      else if (r < 5) procStrobeN = 0;
      else if (r == 5) begin ctrlStrobeN = 0; enHi = 0; end
      step();
    end
    sleep = 0; oeN = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule